// File: doc/BRIEF.md
# Matching Request Queue

This block is a shared hardware queue. Any number of requesters send it enqueue (write) and dequeue (read) requests over one request stream. Each read carries a response address. A read that finds data in the queue is answered at once. A read that finds no data is not refused. Instead it is parked in the same storage that holds data, and it waits there for a later write. When a write meets a parked read, or a read meets stored data, the block sends out one response packet. The packet carries the write's data to the read's response address.

The storage therefore holds one of two kinds of entry at any moment: data words or waiting readers. It never holds both kinds at once, and a kind register records which kind it holds. Both kinds are served oldest first.

The queue can be built already holding a number of copies of a token word. With one token the queue works as a lock: a read acquires the token and a write gives it back. With several tokens it works as a counting semaphore.

Both edges of the block are valid/ready streams:
- A transfer happens on a clock edge where valid and ready are both high.
- `req_ready` may depend on `req_write`. A request that would be stored waits while the storage is full. A request that would be matched waits while the response register is occupied and not being drained.
- The response register holds its packet unchanged until it is taken.

Top module: `match_queue`

## Requirements
- R1: After reset the queue holds INIT_TOKENS entries of kind data, each equal to TOKEN_VALUE, and `rsp_valid` is 0.
- R2: An accepted read, while data is held, removes the oldest data word. On the next cycle it presents a response with `rsp_addr` equal to the read's `req_addr` and `rsp_data` equal to that word.
- R3: An accepted read, while no data is held, is stored as a waiting reader and produces no response.
- R4: An accepted write, while readers wait, removes the oldest reader. On the next cycle it presents a response with `rsp_addr` equal to that reader's address and `rsp_data` equal to the write's `req_data`.
- R5: An accepted write, while no reader waits, is stored as data and produces no response.
- R6: Stored data words and waiting readers are each consumed in arrival order, and each entry is consumed exactly once.
- R7: A request that would be stored is held off (`req_ready`=0) when DEPTH entries are held. A request that would be matched is still accepted in that state.
- R8: While `rsp_valid`=1 and `rsp_ready`=0:
  - `rsp_addr` and `rsp_data` stay unchanged.
  - A request that would be matched is held off.
  - The request that the stall held off is accepted on the same edge that drains the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = enqueue (write), 0 = dequeue (read) |
| req_data | input | DATA_W | Data word for a write |
| req_addr | input | ADDR_W | Response address for a read |
| rsp_valid | output | 1 | Response packet present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | ADDR_W | Destination address of the packet |
| rsp_data | output | DATA_W | Delivered data word |

## Verification
Each of the following faults shows at the ports within one cycle of the next request that depends on the faulty state:
- A wrong kind register makes a read that should park produce a response.
- The same fault makes a write that should be matched vanish silently into storage.
- A wrong head pointer delivers a word or address that is not the oldest.
- A wrong occupancy count moves the point where `req_ready` drops away from DEPTH entries.

The tests fill the storage with each kind until it is full and stall the response register. They compare every packet with the arrival order worked out in the bench, so both loss and duplication of entries are caught.

// File: rtl/match_queue_pkg.sv
package match_queue_pkg;
  // Which kind of entry the shared storage currently holds
  typedef enum logic {
    KIND_DATA   = 1'b0,
    KIND_READER = 1'b1
  } entry_kind_e;
endpackage

// File: rtl/mq_entry_store.sv
module mq_entry_store
  import match_queue_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int ENTRY_W     = 16,
  parameter int INIT_TOKENS = 0,
  parameter logic [ENTRY_W-1:0] TOKEN_VALUE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  entry_kind_e        push_kind,
  input  logic [ENTRY_W-1:0] push_value,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head_value,
  output entry_kind_e        held_kind,
  output logic               is_empty,
  output logic               is_full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX  = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] INIT_WPTR = PTR_W'(INIT_TOKENS % DEPTH);
  localparam logic [CNT_W-1:0] INIT_CNT  = CNT_W'(INIT_TOKENS);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [ENTRY_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]   wr_idx, rd_idx;
  logic [CNT_W-1:0]   count;
  entry_kind_e        kind_q;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      localparam logic [ENTRY_W-1:0] RST_VAL = (g < INIT_TOKENS) ? TOKEN_VALUE : '0;
      always_ff @(posedge clk) begin
        if (!rst_n)
          slots[g] <= RST_VAL;
        else if (push && wr_idx == PTR_W'(g))
          slots[g] <= push_value;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= INIT_WPTR;
      rd_idx <= '0;
      count  <= INIT_CNT;
      kind_q <= KIND_DATA;
    end else begin
      if (push) begin
        wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
        if (count == '0)
          kind_q <= push_kind;
      end
      if (pop)
        rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_value = slots[rd_idx];
  assign held_kind  = kind_q;
  assign is_empty   = (count == '0);
  assign is_full    = (count == FULL_CNT);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT && push) |-> pop);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
  p_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count != '0) |-> (push_kind == kind_q));
endmodule

// File: rtl/mq_match_ctrl.sv
module mq_match_ctrl
  import match_queue_pkg::*;
(
  input  logic        req_valid,
  input  logic        req_write,
  input  entry_kind_e held_kind,
  input  logic        store_empty,
  input  logic        store_full,
  input  logic        slot_free,
  output logic        req_ready,
  output logic        do_push,
  output entry_kind_e push_kind,
  output logic        do_pop,
  output logic        emit
);
  logic pairs_up;
  logic accept;

  // A write pairs with a waiting reader, a read pairs with stored data
  always_comb begin
    pairs_up = 1'b0;
    if (!store_empty)
      pairs_up = req_write ? (held_kind == KIND_READER) : (held_kind == KIND_DATA);
  end

  assign req_ready = pairs_up ? slot_free : !store_full;
  assign accept    = req_valid && req_ready;
  assign do_pop    = accept && pairs_up;
  assign emit      = do_pop;
  assign do_push   = accept && !pairs_up;
  assign push_kind = req_write ? KIND_DATA : KIND_READER;
endmodule

// File: rtl/mq_resp_slot.sv
module mq_resp_slot #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic              slot_free,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  assign slot_free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_data  <= '0;
    end else if (slot_free) begin
      rsp_valid <= load;
      if (load) begin
        rsp_addr <= load_addr;
        rsp_data <= load_data;
      end
    end
  end

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_data)));
  p_no_load_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !load);
endmodule

// File: rtl/match_queue.sv
module match_queue
  import match_queue_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int INIT_TOKENS = 0,
  parameter logic [DATA_W-1:0] TOKEN_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_data,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int ENTRY_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;

  logic [ENTRY_W-1:0] head_value, push_value;
  entry_kind_e        held_kind, push_kind;
  logic               store_empty, store_full, slot_free;
  logic               do_push, do_pop, emit;
  logic [ADDR_W-1:0]  emit_addr;
  logic [DATA_W-1:0]  emit_data;

  assign push_value = req_write ? ENTRY_W'(req_data) : ENTRY_W'(req_addr);

  mq_entry_store #(
    .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .INIT_TOKENS(INIT_TOKENS),
    .TOKEN_VALUE(ENTRY_W'(TOKEN_VALUE))
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(do_push), .push_kind(push_kind), .push_value(push_value),
    .pop(do_pop), .head_value(head_value), .held_kind(held_kind),
    .is_empty(store_empty), .is_full(store_full)
  );

  mq_match_ctrl u_ctrl (
    .req_valid(req_valid), .req_write(req_write), .held_kind(held_kind),
    .store_empty(store_empty), .store_full(store_full), .slot_free(slot_free),
    .req_ready(req_ready), .do_push(do_push), .push_kind(push_kind),
    .do_pop(do_pop), .emit(emit)
  );

  // Matched write: address from the parked reader, data from the request.
  // Matched read: address from the request, data from storage.
  assign emit_addr = req_write ? head_value[ADDR_W-1:0] : req_addr;
  assign emit_data = req_write ? req_data : head_value[DATA_W-1:0];

  mq_resp_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .load(emit), .load_addr(emit_addr), .load_data(emit_data),
    .slot_free(slot_free),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  p_write_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !store_empty && held_kind == KIND_READER)
    |=> (rsp_valid && rsp_data == $past(req_data)));
  p_read_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !store_empty && held_kind == KIND_DATA)
    |=> (rsp_valid && rsp_addr == $past(req_addr)));
  p_park_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && store_empty && slot_free) |=> !rsp_valid);
  p_store_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && (store_empty || held_kind == KIND_DATA) && slot_free)
    |=> !rsp_valid);
  p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (store_full && req_valid && req_write && held_kind == KIND_DATA) |-> !req_ready);
endmodule

// File: tb/match_queue_bench.sv
module match_queue_bench;
  localparam int DEPTH = 4;
  localparam int W     = 16;
  localparam logic [W-1:0] TOKEN = 16'h00A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [W-1:0] req_data = '0, req_addr = '0;
  logic req_ready, rsp_valid;
  logic [W-1:0] rsp_addr, rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  match_queue #(.DEPTH(DEPTH), .DATA_W(W), .ADDR_W(W), .INIT_TOKENS(2), .TOKEN_VALUE(TOKEN))
  u_match_queue (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_data(req_data), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  // {is_write, value, expect_rsp, exp_addr, exp_data}
  localparam logic [49:0] VEC [12] = '{
    {1'b0, 16'h0100, 1'b1, 16'h0100, 16'h00A5},  // R1 R2 token taken
    {1'b0, 16'h0101, 1'b1, 16'h0101, 16'h00A5},  // R1 R2 second token
    {1'b0, 16'h0200, 1'b0, 16'h0000, 16'h0000},  // R3 parked
    {1'b0, 16'h0201, 1'b0, 16'h0000, 16'h0000},  // R3 parked
    {1'b1, 16'h1111, 1'b1, 16'h0200, 16'h1111},  // R4 R6 oldest reader
    {1'b1, 16'h2222, 1'b1, 16'h0201, 16'h2222},  // R4 R6
    {1'b1, 16'h3333, 1'b0, 16'h0000, 16'h0000},  // R5 stored
    {1'b1, 16'h4444, 1'b0, 16'h0000, 16'h0000},  // R5 stored
    {1'b0, 16'h0300, 1'b1, 16'h0300, 16'h3333},  // R2 R6 oldest data
    {1'b0, 16'h0301, 1'b1, 16'h0301, 16'h4444},  // R2 R6
    {1'b0, 16'h0302, 1'b0, 16'h0000, 16'h0000},  // R3 parked
    {1'b1, 16'h5555, 1'b1, 16'h0302, 16'h5555}   // R4
  };

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the request removed
  task automatic send(input bit wr, input logic [W-1:0] v, input bit ev,
                      input logic [W-1:0] ea, input logic [W-1:0] ed, input string tag);
    req_valid = 1'b1; req_write = wr; req_data = v; req_addr = v;
    #1 check(req_ready == 1'b1, {tag, " ready"}, W'(req_ready), W'(1));
    @(negedge clk);
    check(rsp_valid == ev, {tag, " rsp_valid"}, W'(rsp_valid), W'(ev));
    if (ev) begin
      check(rsp_addr == ea, {tag, " rsp_addr"}, rsp_addr, ea);
      check(rsp_data == ed, {tag, " rsp_data"}, rsp_data, ed);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check(rsp_valid == 1'b0, "R1 reset rsp_valid", W'(rsp_valid), W'(0));
    check(req_ready == 1'b1, "R1 reset req_ready", W'(req_ready), W'(1));

    for (int i = 0; i < 12; i++)
      send(VEC[i][49], VEC[i][48:33], VEC[i][32], VEC[i][31:16], VEC[i][15:0], "R6 table");

    // R7: full of data, a further write is held, a read still passes
    for (int i = 0; i < DEPTH; i++) send(1'b1, 16'h0A01 + W'(i), 1'b0, '0, '0, "R5 fill");
    req_valid = 1'b1; req_write = 1'b1; req_data = 16'h0A05;
    #1 check(req_ready == 1'b0, "R7 full write held", W'(req_ready), W'(0));
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7 no response while held", W'(rsp_valid), W'(0));
    req_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      send(1'b0, 16'h0400 + W'(i), 1'b1, 16'h0400 + W'(i), 16'h0A01 + W'(i), "R7 drain full data");

    // R7: full of readers, a further read is held, a write still passes
    for (int i = 0; i < DEPTH; i++) send(1'b0, 16'h0600 + W'(i), 1'b0, '0, '0, "R3 fill");
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0699;
    #1 check(req_ready == 1'b0, "R7 full read held", W'(req_ready), W'(0));
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      send(1'b1, 16'h0C01 + W'(i), 1'b1, 16'h0600 + W'(i), 16'h0C01 + W'(i), "R7 serve readers");

    // R8: stalled response register
    send(1'b1, 16'h0B01, 1'b0, '0, '0, "R5 bp setup");
    send(1'b1, 16'h0B02, 1'b0, '0, '0, "R5 bp setup");
    rsp_ready = 1'b0;
    send(1'b0, 16'h0500, 1'b1, 16'h0500, 16'h0B01, "R8 first");
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0501;
    #1 check(req_ready == 1'b0, "R8 match held", W'(req_ready), W'(0));
    @(negedge clk);
    check(rsp_valid == 1'b1, "R8 still valid", W'(rsp_valid), W'(1));
    check(rsp_addr == 16'h0500, "R8 addr stable", rsp_addr, 16'h0500);
    check(rsp_data == 16'h0B01, "R8 data stable", rsp_data, 16'h0B01);
    rsp_ready = 1'b1;
    #1 check(req_ready == 1'b1, "R8 ready on drain", W'(req_ready), W'(1));
    @(negedge clk);
    check(rsp_addr == 16'h0501, "R8 next addr", rsp_addr, 16'h0501);
    check(rsp_data == 16'h0B02, "R8 next data", rsp_data, 16'h0B02);
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R6 no duplicate", W'(rsp_valid), W'(0));
    done = 1'b1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule